// File: doc/BRIEF.md
# Configuration Image Name Locator

The block searches a 128-byte configuration image for an 8-byte world-wide name. The image sits in a small memory with a synchronous read port. A pulse on `start` begins a walk from byte 0 through a chain of tagged records. Each record begins with a header byte that tells whether the record is short or long and how far away the next header is. Only long records carrying name 0x0D are opened. Inside such a record the block steps through keyword sub-fields. When it meets the name keyword 0x3C, it collects the eight bytes that follow the sub-field header.

When the walk ends, `done` is high for one cycle. `found` tells whether a name was captured. `wwn` carries the name, with the first image byte in the top byte, and `offset` gives the index of that first byte. The block fetches one byte per cycle: it presents the next address while it examines the current byte. A scan therefore lasts one cycle per byte read plus one cycle for the result.

Top module: `wwn_locator`

## Requirements
- R1: A start pulse accepted while idle fetches byte 0 first. Each later cycle consumes exactly one fetched byte. `done` rises in the cycle after the last byte consumed and is high for exactly one cycle.
- R2: A header byte with bit 7 clear is a short record. The next header lies 1 + bits[2:0] bytes further on.
- R3: A short record whose bits[6:3] equal 4'hF stops the scan, with `found` low.
- R4: A header byte with bit 7 set is a long record named by bits[6:0]. Its next header lies 3 + L bytes further on, where L is the byte after the header plus 256 times the byte after that. A long record named anything other than 0x0D is passed over without looking at its body.
- R5: In a long record named 0x0D, sub-fields start 3 bytes past the header. A sub-field's keyword is its first byte ANDed with 0x3F. Its length M comes from the next two bytes, low byte first, and the next sub-field starts 3 + M bytes further on. A sub-field is examined only if it starts before the record's end.
- R6: If the first body byte of a 0x0D record is 0x3B, the record is taken to be 6 bytes long and its body is not searched.
- R7: On keyword 0x3C, the 8 bytes after the sub-field's 3-byte header form `wwn`, with the first byte in bits 63:56. `offset` is the index of that first byte and `found` is high.
- R8: When no name is captured, `found`, `offset` and `wwn` are all zero at `done`.
- R9: The scan ends without a match when a header index reaches 128 or when any needed byte lies beyond index 127, even if this happens partway through capturing the name.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan (ignored while busy) |
| memAddr | output | 7 | Image read address, registered by the memory |
| memData | input | 8 | Byte read at the address of the previous cycle |
| done | output | 1 | One-cycle end-of-scan strobe |
| found | output | 1 | Name captured in the last scan |
| wwn | output | 64 | Captured name, first byte most significant |
| offset | output | 7 | Index of the name's first byte, or 0 |

## Verification
The scan is tried on several images:
- An image of short records only, which marks short-record stepping and the header limit.
- Images with foreign long records whose bodies hold 0x3C bytes, which tell skipping apart from searching.
- A 0x3B-led record ahead of a real one, a masked keyword byte 0xFC, and a sub-field that would sit past its record's end, which together separate the keyword, mask and length rules.
- Records placed so that the name ends exactly at index 127, or one byte beyond it, which pin the range rule.
- A set of arbitrary byte images.

Every clock, the bench compares `done` against a behavioural reference model. This pins the exact number of bytes fetched, so a wrong step size shows up even when the final result happens to agree.

// File: rtl/wwn_scan_pkg.sv
package wwn_scan_pkg;

  localparam int LEN_W = 16;  // two-byte little-endian length fields

  typedef enum logic [2:0] {
    PS_HOLD,
    PS_ZERO,
    PS_INC,
    PS_SMALL,
    PS_RECEND_NEW,
    PS_RECEND,
    PS_SKIP6,
    PS_SUBNEXT
  } ptr_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_LEN1,
    ST_LEN2,
    ST_BODY,
    ST_SUB,
    ST_SL1,
    ST_SL2,
    ST_CAP,
    ST_FIN
  } scan_state_e;

  typedef struct packed {
    ptr_sel_e ptrSel;
    logic     clear;
    logic     ldRecBase;
    logic     ldLenLo;
    logic     ldRecEnd;
    logic     ldSubBase;
    logic     ldOffset;
    logic     shiftWwn;
    logic     setFound;
  } scan_ctrl_t;

  typedef struct packed {
    logic inRange;     // selected next address lies inside the image
    logic pastRecEnd;  // current pointer at or beyond record end
    logic subBeyond;   // next sub-field would start at or beyond record end
    logic capLast;     // final name byte is being taken
  } scan_stat_t;

endpackage

// File: rtl/wwn_scan_datapath.sv
module wwn_scan_datapath
  import wwn_scan_pkg::*;
#(
  parameter int IMG_BYTES = 128,
  parameter int WWN_BYTES = 8,
  localparam int ADDR_W = $clog2(IMG_BYTES),
  localparam int PW = ADDR_W + LEN_W,
  localparam int WWN_W = 8 * WWN_BYTES,
  localparam int CNT_W = $clog2(WWN_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  scan_ctrl_t        ctrl,
  input  logic [7:0]        memData,
  output logic [ADDR_W-1:0] memAddr,
  output scan_stat_t        stat,
  output logic [WWN_W-1:0]  wwnQ,
  output logic [ADDR_W-1:0] offsetQ,
  output logic              foundQ
);

  logic [PW-1:0]    ptr, recBase, recEnd, subBase, nxtPtr;
  logic [PW-1:0]    lenWord, candInc, candSmall, candRecEndNew, candSkip6, candSubNext;
  logic [7:0]       lenLo;
  logic [CNT_W-1:0] capCnt;

  always_comb begin
    lenWord       = PW'({memData, lenLo});
    candInc       = ptr + PW'(1);
    candSmall     = ptr + PW'(1) + PW'(memData[2:0]);
    candRecEndNew = recBase + PW'(3) + lenWord;
    candSkip6     = recBase + PW'(6);
    candSubNext   = subBase + PW'(3) + lenWord;
    unique case (ctrl.ptrSel)
      PS_ZERO:       nxtPtr = '0;
      PS_INC:        nxtPtr = candInc;
      PS_SMALL:      nxtPtr = candSmall;
      PS_RECEND_NEW: nxtPtr = candRecEndNew;
      PS_RECEND:     nxtPtr = recEnd;
      PS_SKIP6:      nxtPtr = candSkip6;
      PS_SUBNEXT:    nxtPtr = candSubNext;
      default:       nxtPtr = ptr;
    endcase
  end

  assign memAddr         = nxtPtr[ADDR_W-1:0];
  assign stat.inRange    = nxtPtr < PW'(IMG_BYTES);
  assign stat.pastRecEnd = ptr >= recEnd;
  assign stat.subBeyond  = candSubNext >= recEnd;
  assign stat.capLast    = capCnt == CNT_W'(WWN_BYTES - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      recBase <= '0;
      recEnd  <= '0;
      subBase <= '0;
      lenLo   <= '0;
      capCnt  <= '0;
      wwnQ    <= '0;
      offsetQ <= '0;
      foundQ  <= 1'b0;
    end else begin
      ptr <= nxtPtr;
      if (ctrl.ldRecBase) recBase <= ptr;
      if (ctrl.ldRecEnd)  recEnd  <= candRecEndNew;
      if (ctrl.ldSubBase) subBase <= ptr;
      if (ctrl.ldLenLo)   lenLo   <= memData;
      if (ctrl.ldOffset)  offsetQ <= candInc[ADDR_W-1:0];
      if (ctrl.shiftWwn) begin
        wwnQ   <= {wwnQ[WWN_W-9:0], memData};
        capCnt <= capCnt + CNT_W'(1);
      end
      if (ctrl.setFound) foundQ <= 1'b1;
      if (ctrl.clear) begin
        wwnQ    <= '0;
        capCnt  <= '0;
        offsetQ <= '0;
        foundQ  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wwn_scan_ctrl.sv
module wwn_scan_ctrl
  import wwn_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] memData,
  input  scan_stat_t stat,
  output scan_ctrl_t ctrl,
  output logic       done,
  output logic       atHeader
);

  scan_state_e state, nxtState;
  logic        isTarget, kwHit;

  always_comb begin
    ctrl     = '0;
    nxtState = state;
    unique case (state)
      ST_IDLE: if (start) begin
        ctrl.clear  = 1'b1;
        ctrl.ptrSel = PS_ZERO;
        nxtState    = ST_HDR;
      end
      ST_HDR: begin
        ctrl.ldRecBase = 1'b1;
        if (!memData[7]) begin
          if (memData[6:3] == 4'hF) nxtState = ST_FIN;
          else begin
            ctrl.ptrSel = PS_SMALL;
            nxtState    = stat.inRange ? ST_HDR : ST_FIN;
          end
        end else begin
          ctrl.ptrSel = PS_INC;
          nxtState    = stat.inRange ? ST_LEN1 : ST_FIN;
        end
      end
      ST_LEN1: begin
        ctrl.ldLenLo = 1'b1;
        ctrl.ptrSel  = PS_INC;
        nxtState     = stat.inRange ? ST_LEN2 : ST_FIN;
      end
      ST_LEN2: begin
        ctrl.ldRecEnd = 1'b1;
        if (isTarget) begin
          ctrl.ptrSel = PS_INC;
          nxtState    = stat.inRange ? ST_BODY : ST_FIN;
        end else begin
          ctrl.ptrSel = PS_RECEND_NEW;
          nxtState    = stat.inRange ? ST_HDR : ST_FIN;
        end
      end
      ST_BODY, ST_SUB: begin
        if (state == ST_BODY && memData == 8'h3B) begin
          ctrl.ptrSel = PS_SKIP6;
          nxtState    = stat.inRange ? ST_HDR : ST_FIN;
        end else if (stat.pastRecEnd) begin
          ctrl.ptrSel = PS_RECEND;
          nxtState    = stat.inRange ? ST_HDR : ST_FIN;
        end else begin
          ctrl.ldSubBase = 1'b1;
          ctrl.ptrSel    = PS_INC;
          nxtState       = stat.inRange ? ST_SL1 : ST_FIN;
        end
      end
      ST_SL1: begin
        ctrl.ldLenLo = 1'b1;
        ctrl.ptrSel  = PS_INC;
        nxtState     = stat.inRange ? ST_SL2 : ST_FIN;
      end
      ST_SL2: begin
        if (kwHit) begin
          ctrl.ldOffset = 1'b1;
          ctrl.ptrSel   = PS_INC;
          nxtState      = stat.inRange ? ST_CAP : ST_FIN;
        end else if (stat.subBeyond) begin
          ctrl.ptrSel = PS_RECEND;
          nxtState    = stat.inRange ? ST_HDR : ST_FIN;
        end else begin
          ctrl.ptrSel = PS_SUBNEXT;
          nxtState    = stat.inRange ? ST_SUB : ST_FIN;
        end
      end
      ST_CAP: begin
        ctrl.shiftWwn = 1'b1;
        if (stat.capLast) begin
          ctrl.setFound = 1'b1;
          nxtState      = ST_FIN;
        end else begin
          ctrl.ptrSel = PS_INC;
          nxtState    = stat.inRange ? ST_CAP : ST_FIN;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isTarget <= 1'b0;
      kwHit    <= 1'b0;
    end else begin
      state <= nxtState;
      if (state == ST_HDR) isTarget <= memData[7] && (memData[6:0] == 7'h0D);
      if (state == ST_BODY || state == ST_SUB) kwHit <= memData[5:0] == 6'h3C;
    end
  end

  assign done     = state == ST_FIN;
  assign atHeader = state == ST_HDR;

endmodule

// File: rtl/wwn_locator.sv
module wwn_locator
  import wwn_scan_pkg::*;
#(
  parameter int IMG_BYTES = 128,
  parameter int WWN_BYTES = 8,
  localparam int ADDR_W = $clog2(IMG_BYTES),
  localparam int WWN_W = 8 * WWN_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData,
  output logic              done,
  output logic              found,
  output logic [WWN_W-1:0]  wwn,
  output logic [ADDR_W-1:0] offset
);

  scan_ctrl_t        ctrl;
  scan_stat_t        stat;
  logic [WWN_W-1:0]  wwnQ;
  logic [ADDR_W-1:0] offsetQ;
  logic              foundQ, atHeader;

  wwn_scan_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .memData(memData),
    .stat(stat), .ctrl(ctrl), .done(done), .atHeader(atHeader)
  );

  wwn_scan_datapath #(.IMG_BYTES(IMG_BYTES), .WWN_BYTES(WWN_BYTES)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .memData(memData),
    .memAddr(memAddr), .stat(stat), .wwnQ(wwnQ), .offsetQ(offsetQ),
    .foundQ(foundQ)
  );

  assign found  = foundQ;
  assign wwn    = foundQ ? wwnQ : '0;
  assign offset = foundQ ? offsetQ : '0;

endmodule

// File: rtl/wwn_locator_checks.sv
module wwn_locator_checks #(
  parameter int IMG_BYTES = 128,
  parameter int WWN_BYTES = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              found,
  input logic              atHeader,
  input logic [7:0]        memData,
  input logic [ADDR_W-1:0] offset
);

  // R1: result strobe lasts a single cycle
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: a short end record at a header finishes the scan without a name
  assert_end_tag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (atHeader && !memData[7] && memData[6:3] == 4'hF) |=> (done && !found));

  // R5: a name sits behind a record header and a sub-field header
  assert_min_offset_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && found) |-> (offset >= ADDR_W'(6)));

  // R9: a reported name lies wholly inside the image
  assert_name_fits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && found) |-> (int'(offset) + WWN_BYTES <= IMG_BYTES));

endmodule

bind wwn_locator wwn_locator_checks #(
  .IMG_BYTES(IMG_BYTES), .WWN_BYTES(WWN_BYTES), .ADDR_W(ADDR_W)
) uChecks (
  .clk(clk), .rstN(rstN), .done(done), .found(found),
  .atHeader(atHeader), .memData(memData), .offset(offset)
);

// File: tb/wwn_locator_test.sv
module wwn_locator_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  memAddr;
  logic [7:0]  memData = 8'h00;
  logic        done, found;
  logic [63:0] wwn;
  logic [6:0]  offset;

  logic [7:0]  img [128];
  int          checks = 0;
  int          fails = 0;
  bit          ended = 0;

  always #4 clk = ~clk;

  always @(posedge clk) memData <= img[memAddr];

  wwn_locator uut (
    .clk(clk), .rstN(rstN), .start(start), .memAddr(memAddr),
    .memData(memData), .done(done), .found(found), .wwn(wwn), .offset(offset)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // behavioural reference: walks the image and counts every byte fetched
  task automatic refScan(output bit f, output logic [63:0] w, output int off, output int reads);
    int i, j, nj, recEnd, ln;
    bit stop, leave;
    logic [7:0] z, b;
    f = 0; w = 0; off = 0; reads = 0; i = 0; stop = 0;
    while (!stop && i < 128) begin
      z = img[i]; reads++;
      if (!z[7]) begin
        if (z[6:3] == 4'hF) begin stop = 1; continue; end
        i = i + 1 + int'(z[2:0]);
        continue;
      end
      if (i + 1 > 127) begin stop = 1; continue; end
      reads++;
      if (i + 2 > 127) begin stop = 1; continue; end
      reads++;
      recEnd = i + 3 + int'(img[i+1]) + 256 * int'(img[i+2]);
      if (z[6:0] != 7'h0D) begin i = recEnd; continue; end
      j = i + 3;
      if (j > 127) begin stop = 1; continue; end
      reads++; b = img[j];
      if (b == 8'h3B) begin i = i + 6; continue; end
      leave = 0;
      while (!leave && !stop) begin
        if (j >= recEnd) begin i = recEnd; leave = 1; continue; end
        if (j + 1 > 127) begin stop = 1; continue; end
        reads++;
        if (j + 2 > 127) begin stop = 1; continue; end
        reads++;
        ln = int'(img[j+1]) + 256 * int'(img[j+2]);
        if (b[5:0] == 6'h3C) begin
          stop = 1;
          f = 1;
          for (int k = 0; k < 8; k++) begin
            if (j + 3 + k > 127) begin f = 0; break; end
            reads++;
            w = {w[55:0], img[j+3+k]};
          end
          off = j + 3;
          continue;
        end
        nj = j + 3 + ln;
        if (nj >= recEnd) begin i = recEnd; leave = 1; continue; end
        if (nj > 127) begin stop = 1; continue; end
        j = nj; reads++; b = img[j];
      end
    end
    if (!f) begin w = 0; off = 0; end
  endtask

  task automatic runCase(string req);
    bit eF; logic [63:0] eW; int eOff, eReads;
    refScan(eF, eW, eOff, eReads);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int cyc = 1; cyc <= eReads + 1; cyc++) begin
      check(done === (cyc == eReads + 1), "R1", 64'(done), 64'(cyc == eReads + 1));
      if (cyc == eReads + 1) begin
        check(found === eF, req, 64'(found), 64'(eF));
        check(wwn === eW, req, wwn, eW);
        check(offset === 7'(eOff), req, 64'(offset), 64'(eOff));
        if (!eF) check(wwn === 0 && offset === 0, "R8", wwn, 64'(0));
      end
      @(negedge clk);
    end
    check(done === 1'b0, "R1", 64'(done), 64'(0));
  endtask

  task automatic fill(logic [7:0] v);
    for (int k = 0; k < 128; k++) img[k] = v;
  endtask

  task automatic putName(int at);
    for (int k = 0; k < 8; k++) img[at+k] = 8'(8'hA0 + k * 8'h11 + at);
  endtask

  initial begin
    int cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog expired");
        finishRun();
      end
    end
  end

  initial begin
    fill(8'h78);
    repeat (3) @(negedge clk);
    check(done === 1'b0 && found === 1'b0, "R8", 64'({done, found}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(done === 1'b0 && found === 1'b0 && offset === 0, "R8", 64'(offset), 64'(0));

    // R7 basic: short record, then 0x0D record with a plain sub-field then the name
    fill(8'h78);
    img[0] = 8'h0A; img[1] = 8'h11; img[2] = 8'h22;
    img[3] = 8'h8D; img[4] = 8'd16; img[5] = 8'h00;
    img[6] = 8'h10; img[7] = 8'h02; img[8] = 8'h00; img[9] = 8'hAA; img[10] = 8'hBB;
    img[11] = 8'h3C; img[12] = 8'h08; img[13] = 8'h00;
    putName(14);
    runCase("R7");
    check(offset === 7'd14 && found === 1'b1, "R2", 64'(offset), 64'(14));

    // R3: end tag at index 0
    fill(8'h78);
    runCase("R3");

    // R6: 0x3B-led record is skipped as 6 bytes
    fill(8'h78);
    img[0] = 8'h8D; img[1] = 8'h20; img[2] = 8'h00; img[3] = 8'h3B;
    img[4] = 8'h3C; img[5] = 8'h08;
    img[6] = 8'h8D; img[7] = 8'd11; img[8] = 8'h00;
    img[9] = 8'h3C; img[10] = 8'h08; img[11] = 8'h00;
    putName(12);
    runCase("R6");

    // R4: foreign long record holding keyword-like bytes is passed over
    fill(8'h78);
    img[0] = 8'h90; img[1] = 8'd12; img[2] = 8'h00;
    img[3] = 8'h3C; img[4] = 8'h08; img[5] = 8'h00;
    putName(6);
    runCase("R4");

    // R5: keyword byte 0xFC masks to 0x3C
    fill(8'h78);
    img[0] = 8'h8D; img[1] = 8'd11; img[2] = 8'h00;
    img[3] = 8'hFC; img[4] = 8'h08; img[5] = 8'h00;
    putName(6);
    runCase("R5");

    // R5: sub-field that would start at the record end is not examined
    fill(8'h78);
    img[0] = 8'h8D; img[1] = 8'd5; img[2] = 8'h00;
    img[3] = 8'h10; img[4] = 8'h02; img[5] = 8'h00;
    img[8] = 8'h3C; img[9] = 8'h08; img[10] = 8'h00;
    runCase("R5");

    // R9: name ends exactly at index 127
    fill(8'h78);
    for (int k = 0; k < 14; k++) img[k*8] = 8'h07;
    img[112] = 8'h01;
    img[114] = 8'h8D; img[115] = 8'd11; img[116] = 8'h00;
    img[117] = 8'h3C; img[118] = 8'h08; img[119] = 8'h00;
    putName(120);
    runCase("R9");

    // R9: name would cross index 127
    fill(8'h78);
    for (int k = 0; k < 14; k++) img[k*8] = 8'h07;
    img[112] = 8'h02;
    img[115] = 8'h8D; img[116] = 8'd11; img[117] = 8'h00;
    img[118] = 8'h3C; img[119] = 8'h08; img[120] = 8'h00;
    runCase("R9");

    // R9: long header at 126 needs a length byte beyond the image
    fill(8'h78);
    for (int k = 0; k < 15; k++) img[k*8] = 8'h07;
    img[120] = 8'h05; img[126] = 8'h8D;
    runCase("R9");

    // R2: short records only, headers run off the end
    fill(8'h00);
    runCase("R2");

    // arbitrary images
    for (int n = 0; n < 12; n++) begin
      for (int k = 0; k < 128; k++) img[k] = 8'($urandom);
      runCase("R4");
    end

    finishRun();
  end

endmodule